// File: doc/BRIEF.md
# Peripheral Clock Gate Controller

This block holds the on/off state of up to 64 peripheral clock enables, split into two banks of 32. Software changes gates through a simple register bus without read-modify-write. Each bank has one write-only register that switches gates on for every 1 bit, and one write-only register that switches gates off for every 1 bit. A 0 bit in either register leaves its gate alone, so separate drivers can touch their own gates without racing each other.

Each gate has a requested state and an actual state. The actual state follows the request after a fixed, parameterised settling delay. This delay stands in for the time a real clock switch-over takes. Software polls the status bit until it matches the request. The 64-bit enable output carries the actual state. Clock index N lives in bank N/32 at bit N mod 32. Six indices are reserved and can never be switched on. At reset every gate is off except index 2, which stays on so that the memory controller keeps its clock through boot.

Top module: `pclk_gate_ctl`

## Requirements
- R1: After reset every request and status bit is 0 except index 2 (bank 0, bit 2), which is 1, so `clk_en` equals 64'h4.
- R2: A write to offset 0x24 (bank 0) or 0x34 (bank 1) sets each request bit whose data bit is 1 and leaves the request bits whose data bit is 0 unchanged.
- R3: Indices 32 to 35, 55 and 57 (bank 1 bits 0-3, 23 and 25, mask 0x0280000F) can never be set. Their request bits, their status bits and `clk_en` read 0.
- R4: A write to offset 0x28 (bank 0) or 0x38 (bank 1) clears each request bit whose data bit is 1 and leaves the other request bits unchanged.
- R5: While `bus_rd` is 1, offset 0x2C (bank 0) and offset 0x3C (bank 1) return the request register.
- R6: While `bus_rd` is 1, offset 0x30 (bank 0) and offset 0x40 (bank 1) return the status register. A status bit takes the value of its request SETTLE_CYC clock edges after the edge at which the request changed, and `clk_en` equals the status bits.
- R7: A change of a request bit while its countdown is running restarts the full delay for that bit.
- R8: Index N drives `clk_en[N]`. It is bank 0 bit N for N below 32, and bank 1 bit N-32 otherwise.
- R9: `bus_rdata` is 0 when `bus_rd` is 0, when reading the enable or disable offsets, and when reading any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_rdata | output | 32 | Read data |
| clk_en | output | 64 | Actual clock-enable level per index |

## Verification
The bench uses the default SETTLE_CYC of 4. With this value, a status bit that still lags its request is visible a cycle or two after a write, and the settled value is visible a few idle cycles later. The short window also lets a disable followed by a re-enable land inside one countdown. The bench can then tell a restarted delay from one that was never restarted, at a cycle it knows in advance. The bench writes all ones to bank 1, which exposes every reserved position at once. It also reads an index above 31 on the enable output, which covers the bank split.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int BANK_W    = 32;
  localparam int NUM_BANKS = 2;
  localparam int BUS_W     = 32;
  // bank b sits at BANK_BASE + b*BANK_STRIDE: on, off, request, status
  localparam int BANK_BASE   = 'h24;
  localparam int BANK_STRIDE = 'h10;
  localparam int OFS_ON  = 0;
  localparam int OFS_OFF = 4;
  localparam int OFS_REQ = 8;
  localparam int OFS_STS = 12;

  function automatic logic [BANK_W-1:0] bank_rsv(input int b);
    return (b == 1) ? 32'h0280_000F : 32'h0000_0000;
  endfunction

  function automatic logic [BANK_W-1:0] bank_rst(input int b);
    return (b == 0) ? 32'h0000_0004 : 32'h0000_0000;
  endfunction
endpackage

// File: rtl/pcg_rst_sync.sv
module pcg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pcg_settle.sv
module pcg_settle #(
  parameter int   SETTLE_CYC = 4,
  parameter logic RST_ON     = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_chg,
  input  logic req_nxt,
  input  logic req_q,
  output logic sts_q
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sts_d;
  logic             tick_en;

  always_comb begin
    cnt_d = cnt_q;
    sts_d = sts_q;
    if (req_chg) begin
      cnt_d = CNT_LOAD;
      if (SETTLE_CYC == 0) sts_d = req_nxt;
    end else if (cnt_q == CNT_ONE) begin
      cnt_d = '0;
      sts_d = req_q;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_ONE;
    end
  end

  assign tick_en = req_chg || (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sts_q <= RST_ON;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      sts_q <= sts_d;
    end
  end
endmodule

// File: rtl/pcg_bank.sv
module pcg_bank
  import pcg_pkg::*;
#(
  parameter int BANK_IDX   = 0,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] set_mask,
  input  logic [BANK_W-1:0] clr_mask,
  output logic [BANK_W-1:0] req_q,
  output logic [BANK_W-1:0] sts_q
);
  localparam logic [BANK_W-1:0] RSV = bank_rsv(BANK_IDX);
  localparam logic [BANK_W-1:0] RST = bank_rst(BANK_IDX);

  logic [BANK_W-1:0] req_d;
  logic [BANK_W-1:0] req_chg;
  logic              req_en;

  // clear wins over set when both reach the same bit
  always_comb begin
    req_d   = ((req_q | set_mask) & ~clr_mask) & ~RSV;
    req_chg = req_d ^ req_q;
  end

  assign req_en = |req_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= RST;
    else if (req_en) req_q <= req_d;
  end

  for (genvar i = 0; i < BANK_W; i++) begin : g_bit
    pcg_settle #(
      .SETTLE_CYC (SETTLE_CYC),
      .RST_ON     (RST[i])
    ) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_chg (req_chg[i]),
      .req_nxt (req_d[i]),
      .req_q   (req_q[i]),
      .sts_q   (sts_q[i])
    );
  end
endmodule

// File: rtl/pclk_gate_ctl.sv
module pclk_gate_ctl
  import pcg_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int SETTLE_CYC = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [BUS_W-1:0]              bus_wdata,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  output logic [BUS_W-1:0]              bus_rdata,
  output logic [NUM_BANKS*BANK_W-1:0]   clk_en
);
  localparam int TOT_W = NUM_BANKS * BANK_W;

  logic              rst_sync_n;
  logic [TOT_W-1:0]  req_vec;
  logic [TOT_W-1:0]  sts_vec;

  pcg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [ADDR_W-1:0] A_ON  = ADDR_W'(BANK_BASE + b*BANK_STRIDE + OFS_ON);
    localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(BANK_BASE + b*BANK_STRIDE + OFS_OFF);
    logic [BANK_W-1:0] set_m, clr_m;

    always_comb begin
      set_m = (bus_wr && bus_addr == A_ON)  ? bus_wdata : '0;
      clr_m = (bus_wr && bus_addr == A_OFF) ? bus_wdata : '0;
    end

    pcg_bank #(
      .BANK_IDX   (b),
      .SETTLE_CYC (SETTLE_CYC)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .set_mask (set_m),
      .clr_mask (clr_m),
      .req_q    (req_vec[b*BANK_W +: BANK_W]),
      .sts_q    (sts_vec[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (bus_addr == ADDR_W'(BANK_BASE + b*BANK_STRIDE + OFS_REQ))
          bus_rdata = req_vec[b*BANK_W +: BANK_W];
        if (bus_addr == ADDR_W'(BANK_BASE + b*BANK_STRIDE + OFS_STS))
          bus_rdata = sts_vec[b*BANK_W +: BANK_W];
      end
    end
  end

  assign clk_en = sts_vec;
endmodule

// File: rtl/pclk_gate_ctl_chk.sv
module pclk_gate_ctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_wr,
  input logic [63:0]       req_vec,
  input logic [63:0]       clk_en
);
  localparam logic [63:0] RSV64 = 64'h0280_000F_0000_0000;

  // R3: reserved positions never switch on
  a_r3_rsv_off: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (clk_en & RSV64) == 64'h0 && (req_vec & RSV64) == 64'h0);

  // R2: enable write to bank 0 sets the written ones
  a_r2_set_bank0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_W'('h24)) |=>
      (req_vec[31:0] & $past(bus_wdata)) == $past(bus_wdata));

  // R4: disable write to bank 1 clears the written ones
  a_r4_clr_bank1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == ADDR_W'('h38)) |=>
      (req_vec[63:32] & $past(bus_wdata)) == 32'h0);

  // R2/R4: without a write, requests hold
  a_r4_hold_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_wr |=> $stable(req_vec));

  // R6: a settled gate with a steady request does not move
  a_r6_settled_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!bus_wr && clk_en == req_vec) |=> $stable(clk_en));
endmodule

bind pclk_gate_ctl pclk_gate_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_wr     (bus_wr),
  .req_vec    (req_vec),
  .clk_en     (clk_en)
);

// File: tb/pclk_gate_ctl_test.sv
module pclk_gate_ctl_test;
  localparam int ADDR_W = 8;
  localparam int OP_WR = 0, OP_RD = 1, OP_IDLE = 2;
  localparam int NVEC = 19;

  // {op, addr, data, expected}
  localparam logic [73:0] VEC [NVEC] = '{
    {2'd1, 8'h2C, 32'h0,          32'h0000_0004},  // R1 request
    {2'd1, 8'h30, 32'h0,          32'h0000_0004},  // R1 status
    {2'd0, 8'h24, 32'h0000_00F0,  32'h0},
    {2'd1, 8'h2C, 32'h0,          32'h0000_00F4},  // R2 R5
    {2'd1, 8'h30, 32'h0,          32'h0000_0004},  // R6 lag
    {2'd2, 8'h00, 32'd4,          32'h0},
    {2'd1, 8'h30, 32'h0,          32'h0000_00F4},  // R6 settled
    {2'd0, 8'h28, 32'h0000_0030,  32'h0},
    {2'd1, 8'h2C, 32'h0,          32'h0000_00C4},  // R4
    {2'd0, 8'h34, 32'hFFFF_FFFF,  32'h0},
    {2'd1, 8'h3C, 32'h0,          32'hFD7F_FFF0},  // R3 R5
    {2'd1, 8'h24, 32'h0,          32'h0},          // R9
    {2'd1, 8'h38, 32'h0,          32'h0},          // R9
    {2'd1, 8'h00, 32'h0,          32'h0},          // R9
    {2'd1, 8'h44, 32'h0,          32'h0},          // R9
    {2'd2, 8'h00, 32'd3,          32'h0},
    {2'd1, 8'h40, 32'h0,          32'hFD7F_FFF0},  // R3 R6
    {2'd0, 8'h38, 32'hFFFF_FFFF,  32'h0},
    {2'd1, 8'h3C, 32'h0,          32'h0}           // R4
  };

  logic              clk, rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              bus_wr, bus_rd;
  logic [63:0]       clk_en;
  int                n_chk, n_fail;

  pclk_gate_ctl #(.ADDR_W(ADDR_W), .SETTLE_CYC(4)) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .clk_en    (clk_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    check64(tag, {32'h0, bus_rdata}, {32'h0, exp});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check64("R1 clk_en after reset", clk_en, 64'h4);

    // R9: read strobe low gives zero even on a mapped register
    bus_addr = 8'h2C; #2;
    check64("R9 rd low", {32'h0, bus_rdata}, 64'h0);
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      case (int'(VEC[i][73:72]))
        OP_WR:   wr_reg(VEC[i][71:64], VEC[i][63:32]);
        OP_RD:   rd_chk($sformatf("R2-R9 vector %0d", i), VEC[i][71:64], VEC[i][31:0]);
        default: repeat (int'(VEC[i][63:32])) @(negedge clk);
      endcase
    end

    // R8: index 40 is bank 1 bit 8
    wr_reg(8'h34, 32'h0000_0100);
    repeat (5) @(negedge clk);
    check64("R8 index 40", clk_en, 64'h0000_0100_0000_00C4);

    // R7: change during countdown restarts delay
    wr_reg(8'h24, 32'h0000_0200);   // edge k
    @(negedge clk);                 // k+1
    wr_reg(8'h28, 32'h0000_0200);   // k+2
    wr_reg(8'h24, 32'h0000_0200);   // k+3, reload
    repeat (3) @(negedge clk);      // k+6
    check64("R7 still counting", {63'h0, clk_en[9]}, 64'h0);
    @(negedge clk);                 // k+7
    check64("R7 settled", {63'h0, clk_en[9]}, 64'h1);
    check64("R6 clk_en total", clk_en, 64'h0000_0100_0000_02C4);

    finish_run();
  end
endmodule